// File: doc/BRIEF.md
# Single-Register Saturate and Negate Unit

This block is a small execution datapath for a 32-bit processor. It owns a file of sixteen 32-bit data registers and the four overflow-related status bits, and it performs one-operand operations that read a register and write the result back into the same register. The operations are negation (zero minus the register), clamping to a signed or unsigned byte or halfword range, and bitwise complement.

A request is a single-cycle `valid` strobe with an operation code and a register index. The result and any flag update take effect on the rising clock edge that samples the strobe. When no request is being made, a plain load port lets neighbouring logic place operands into the file. A combinational read port exposes any register. The four status bits are always visible as outputs.

Operation codes on `op`: 0 negate, 1 signed byte clamp, 2 unsigned byte clamp, 3 signed halfword clamp, 4 unsigned halfword clamp, 5 complement. Codes 6 and 7 are not recognised.

Top module: `sat_neg_unit`

## Requirements
- R1: Code 1 treats the register as signed and writes 0xFFFFFF80 when it is below -128, 0x0000007F when it is above 127, and leaves it as it was otherwise.
- R2: Code 2 treats the register as unsigned and writes 0x000000FF when it exceeds 0xFF, otherwise leaves it unchanged.
- R3: Code 3 treats the register as signed and clamps it to the range -32768 (0xFFFF8000) to 32767 (0x00007FFF).
- R4: Code 4 treats the register as unsigned and writes 0x0000FFFF when it exceeds 0xFFFF, otherwise leaves it unchanged.
- R5: Code 0 writes zero minus the register (modulo 2^32) back to it; the overflow flag becomes 1 when the operand was 0x80000000 and 0 for any other operand.
- R6: After negation the sticky overflow flag becomes its old value OR the new overflow flag, and the sticky advance-overflow flag becomes its old value OR the new advance-overflow flag; only reset clears either sticky flag.
- R7: After negation the advance-overflow flag equals bit 31 XOR bit 30 of the result.
- R8: Code 5 writes the bitwise complement of the register and leaves all four flags unchanged.
- R9: Codes 1 to 4 leave all four flags unchanged.
- R10: Register and flag updates occur only on the rising edge at which `valid` is high; with `valid` low no operation takes effect.
- R11: A synchronous active-high reset clears all four flags.
- R12: Codes 6 and 7 write no register and leave all four flags unchanged.
- R13: With `valid` low and `ld_en` high, `ld_data` is written to register `ld_idx` at the edge; with `valid` high the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| valid | input | 1 | Operation request for this cycle |
| op | input | 3 | Operation code |
| idx | input | 4 | Register operated on |
| ld_en | input | 1 | Load request, honoured when `valid` is low |
| ld_idx | input | 4 | Register written by a load |
| ld_data | input | 32 | Value written by a load |
| rd_idx | input | 4 | Register selected for reading |
| rd_data | output | 32 | Contents of register `rd_idx` |
| flag_v | output | 1 | Overflow |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance overflow |
| flag_sav | output | 1 | Sticky advance overflow |

## Verification
The assertions assume that `valid`, `op` and `idx` are driven to known values in every cycle outside reset, and that reset is held for at least one rising edge before the first request. The bench drives all inputs at the falling edge, holds reset for several edges at the start, and gives `op` and `idx` defined values even while `valid` is low, including a cycle where an operation code sits on `op` with `valid` low to show it has no effect.

// File: rtl/sat_neg_unit.sv
module sat_neg_unit #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int OPW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic [OPW-1:0]          op,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [DW-1:0]           ld_data,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data,
  output logic                    flag_v,
  output logic                    flag_sv,
  output logic                    flag_av,
  output logic                    flag_sav
);
  localparam logic [OPW-1:0] OP_NEG  = OPW'(0);
  localparam logic [OPW-1:0] OP_SB   = OPW'(1);
  localparam logic [OPW-1:0] OP_UB   = OPW'(2);
  localparam logic [OPW-1:0] OP_SH   = OPW'(3);
  localparam logic [OPW-1:0] OP_UH   = OPW'(4);
  localparam logic [OPW-1:0] OP_NOT  = OPW'(5);

  localparam logic [DW-1:0] MIN_VAL = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SB_HI = DW'(127);
  localparam logic [DW-1:0] SB_LO = ~DW'(127);
  localparam logic [DW-1:0] SH_HI = DW'(32767);
  localparam logic [DW-1:0] SH_LO = ~DW'(32767);
  localparam logic [DW-1:0] UB_HI = DW'(255);
  localparam logic [DW-1:0] UH_HI = DW'(65535);

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opnd, res, sb_lo, sh_lo;
  logic          known, is_neg, v_new, av_new;

  assign opnd    = rf[idx];
  assign rd_data = rf[rd_idx];

  assign sb_lo = ($signed(opnd) < $signed(SB_LO)) ? SB_LO : opnd;
  assign sh_lo = ($signed(opnd) < $signed(SH_LO)) ? SH_LO : opnd;

  always_comb begin
    known  = 1'b1;
    is_neg = 1'b0;
    res    = opnd;
    case (op)
      OP_NEG: begin res = '0 - opnd; is_neg = 1'b1; end
      OP_SB:  res = ($signed(sb_lo) > $signed(SB_HI)) ? SB_HI : sb_lo;
      OP_UB:  res = (opnd > UB_HI) ? UB_HI : opnd;
      OP_SH:  res = ($signed(sh_lo) > $signed(SH_HI)) ? SH_HI : sh_lo;
      OP_UH:  res = (opnd > UH_HI) ? UH_HI : opnd;
      OP_NOT: res = ~opnd;
      default: known = 1'b0;
    endcase
  end

  assign v_new  = (opnd == MIN_VAL);
  assign av_new = res[DW-1] ^ res[DW-2];

  always_ff @(posedge clk) begin
    if (valid) begin
      if (known) rf[idx] <= res;
    end else if (ld_en) begin
      rf[ld_idx] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_v   <= 1'b0;
      flag_sv  <= 1'b0;
      flag_av  <= 1'b0;
      flag_sav <= 1'b0;
    end else if (valid && is_neg) begin
      flag_v   <= v_new;
      flag_sv  <= flag_sv | v_new;
      flag_av  <= av_new;
      flag_sav <= flag_sav | av_new;
    end
  end
endmodule

module sat_neg_unit_chk #(
  parameter int DW  = 32,
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           valid,
  input logic [OPW-1:0] op,
  input logic [DW-1:0]  opnd,
  input logic [DW-1:0]  res,
  input logic           flag_v,
  input logic           flag_sv,
  input logic           flag_av,
  input logic           flag_sav
);
  localparam logic [DW-1:0] MIN_VAL = {1'b1, {(DW-1){1'b0}}};

  a_r6_sv_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_sv |=> flag_sv);
  a_r6_sav_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_sav |=> flag_sav);
  a_r5_v_from_operand: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OPW'(0)) |=> (flag_v == ($past(opnd) == MIN_VAL)));
  a_r7_av_from_result: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OPW'(0)) |=> (flag_av == ($past(res[DW-1]) ^ $past(res[DW-2]))));
  a_r9_r8_r12_flags_kept: assert property (@(posedge clk) disable iff (rst)
    (valid && op != OPW'(0)) |=> $stable({flag_v, flag_sv, flag_av, flag_sav}));
  a_r10_idle_flags_kept: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable({flag_v, flag_sv, flag_av, flag_sav}));
  a_r1_byte_range: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OPW'(1)) |-> ($signed(res) <= 127 && $signed(res) >= -128));
  a_r4_half_unsigned_range: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OPW'(4)) |-> (res <= DW'(65535)));
endmodule

bind sat_neg_unit sat_neg_unit_chk #(.DW(DW), .OPW(OPW)) i_chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op), .opnd(opnd), .res(res),
  .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav)
);

// File: tb/test_sat_neg_unit.sv
module test_sat_neg_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [3:0]  idx = 4'd0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = 4'd0;
  logic [31:0] ld_data = 32'd0;
  logic [3:0]  rd_idx = 4'd0;
  logic [31:0] rd_data;
  logic        flag_v, flag_sv, flag_av, flag_sav;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mreg [16];
  logic [3:0]  mflag = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_neg_unit i_sat_neg_unit (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .idx(idx),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = r; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mreg[r] = d;
  endtask

  task automatic check_state(input string req, input logic [3:0] r);
    rd_idx = r;
    #1;
    check(req, rd_data, mreg[r]);
    check(req, {28'd0, flag_v, flag_sv, flag_av, flag_sav}, {28'd0, mflag});
  endtask

  function automatic logic [31:0] clamp_s(input logic [31:0] x, input int lo, input int hi);
    if ($signed(x) < lo) return 32'(lo);
    if ($signed(x) > hi) return 32'(hi);
    return x;
  endfunction

  task automatic run_op(input string req, input logic [2:0] code, input logic [3:0] r);
    logic [31:0] x, y;
    logic nv, nav;
    x = mreg[r];
    y = x;
    case (code)
      3'd0: begin
        y = 32'd0 - x;
        nv = (x == 32'h8000_0000);
        nav = y[31] ^ y[30];
        mflag = {nv, mflag[2] | nv, nav, mflag[0] | nav};
      end
      3'd1: y = clamp_s(x, -128, 127);
      3'd2: y = (x > 32'hFF) ? 32'hFF : x;
      3'd3: y = clamp_s(x, -32768, 32767);
      3'd4: y = (x > 32'hFFFF) ? 32'hFFFF : x;
      3'd5: y = ~x;
      default: y = x;
    endcase
    mreg[r] = y;
    @(negedge clk);
    valid = 1'b1; op = code; idx = r;
    @(negedge clk);
    valid = 1'b0;
    check_state(req, r);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mflag = 4'b0000;
    #1;
    check("R11", {28'd0, flag_v, flag_sv, flag_av, flag_sav}, 32'd0);
  endtask

  task automatic t_sat_byte_signed;
    load(4'd1, 32'h0000_0050); run_op("R1", 3'd1, 4'd1);
    load(4'd1, 32'h0000_00FF); run_op("R1", 3'd1, 4'd1);
    load(4'd1, 32'hFFFF_FF00); run_op("R1", 3'd1, 4'd1);
    load(4'd1, 32'hFFFF_FFF0); run_op("R1", 3'd1, 4'd1);
    load(4'd1, 32'h8000_0000); run_op("R1", 3'd1, 4'd1);
    load(4'd1, 32'h7FFF_FFFF); run_op("R1", 3'd1, 4'd1);
  endtask

  task automatic t_sat_byte_unsigned;
    load(4'd2, 32'h0000_0080); run_op("R2", 3'd2, 4'd2);
    load(4'd2, 32'h0000_0100); run_op("R2", 3'd2, 4'd2);
    load(4'd2, 32'hFFFF_FFFF); run_op("R2", 3'd2, 4'd2);
  endtask

  task automatic t_sat_half;
    load(4'd3, 32'h0001_2345); run_op("R3", 3'd3, 4'd3);
    load(4'd3, 32'hFFFF_0000); run_op("R3", 3'd3, 4'd3);
    load(4'd3, 32'h0000_1234); run_op("R3", 3'd3, 4'd3);
    load(4'd4, 32'h0001_0000); run_op("R4", 3'd4, 4'd4);
    load(4'd4, 32'h0000_FFFE); run_op("R4", 3'd4, 4'd4);
    load(4'd4, 32'h8000_0000); run_op("R4", 3'd4, 4'd4);
  endtask

  task automatic t_negate;
    load(4'd5, 32'd5);          run_op("R5", 3'd0, 4'd5);
    load(4'd5, 32'h4000_0000);  run_op("R7", 3'd0, 4'd5);
    load(4'd5, 32'h6000_0000);  run_op("R7", 3'd0, 4'd5);
    load(4'd5, 32'h8000_0000);  run_op("R5", 3'd0, 4'd5);
    load(4'd5, 32'd1);          run_op("R6", 3'd0, 4'd5);
    check("R6", {31'd0, flag_sv & flag_sav}, 32'd1);
  endtask

  task automatic t_not_and_sat_flags;
    load(4'd6, 32'h1234_5678); run_op("R8", 3'd5, 4'd6);
    load(4'd6, 32'h0000_0000); run_op("R8", 3'd5, 4'd6);
    load(4'd6, 32'h0002_0000); run_op("R9", 3'd3, 4'd6);
  endtask

  task automatic t_unknown_and_idle;
    load(4'd7, 32'hCAFE_0001); run_op("R12", 3'd6, 4'd7);
    run_op("R12", 3'd7, 4'd7);
    @(negedge clk);
    op = 3'd5; idx = 4'd7; valid = 1'b0;
    @(negedge clk);
    check_state("R10", 4'd7);
  endtask

  task automatic t_load_blocked;
    load(4'd8, 32'h0000_0011);
    load(4'd9, 32'h0000_0900);
    @(negedge clk);
    valid = 1'b1; op = 3'd5; idx = 4'd8;
    ld_en = 1'b1; ld_idx = 4'd9; ld_data = 32'hDEAD_BEEF;
    mreg[8] = ~mreg[8];
    @(negedge clk);
    valid = 1'b0; ld_en = 1'b0;
    check_state("R13", 4'd9);
    check_state("R13", 4'd8);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mreg[i] = 32'd0;
    t_reset;
    t_sat_byte_signed;
    t_sat_byte_unsigned;
    t_sat_half;
    t_negate;
    t_not_and_sat_flags;
    t_unknown_and_idle;
    t_load_blocked;
    t_reset;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule